// File: doc/BRIEF.md
# Interleaved Chroma 4x4 Reconstruction Engine

This block rebuilds one 4x4 block of a single chroma plane whose samples sit interleaved, byte by byte, with the samples of the companion plane. It takes fifteen AC coefficients together with their inverse-scale and weight entries, a quantizer shift, and a DC value from outside. It dequantizes the AC terms, runs the 4-point integer inverse transform over rows and then columns, and adds the rounded residual to the prediction. The prediction arrives as four 8-byte rows, and only the even bytes of each row belong to this plane.

The destination rows also hold the companion plane, so the engine performs a read-modify-write. It asks for the four current 8-byte destination rows one at a time, keeps at most one request open, and stores each answer. Once all four rows are in hand, it writes them back on four consecutive cycles. In each written row the even bytes carry the reconstructed pixels and the odd bytes carry the old values unchanged. A pulse on `start_i` captures all inputs. Further pulses are ignored until the block is idle again.

Top module: `chroma_recon4x4`

## Requirements
- R1: Each AC coefficient i (1..15, at bits [16(i-1)+15:16(i-1)] of `coef_i`, with the matching scale and weight lanes at the same positions) is dequantized as follows. The low 16 bits of scale times weight are read as a signed value and multiplied by the signed coefficient to give a 32-bit product. That product is shifted left by `qp_i` with 32-bit wrap, has 8 added, is shifted right arithmetically by 4, and is saturated to the range -32768..32767.
- R2: The DC term of the transform input (position row 0, column 0) is always `dc_i`, taken without scaling.
- R3: Prediction row r sits at bits [64r+63:64r] of `pred_i`, and byte k of a row is at bits [8k+7:8k]. Pixel c of row r uses byte 2c. The odd bytes of the prediction have no effect on the result.
- R4: After a start, the four destination rows 0,1,2,3 are each requested once, in that order, and all four responses arrive before the first write.
- R5: In every written row, each odd byte equals the same byte of the old row received for that row index.
- R6: The transform uses 16-bit wrapping arithmetic and runs horizontally on each row first, then vertically on each column. For an input a0..a3 the butterfly computes e0=a0+a2, e1=a0-a2, e2=(a1>>>1)-a3 and e3=a1+(a3>>>1), and outputs e0+e3, e1+e2, e1-e2, e0-e3. The residual is (v+32)>>>6. Even byte 2c of written row r is the prediction pixel plus the residual, clipped to 0..255.
- R7: The four rows are written on consecutive cycles in the order 0,1,2,3, and `done_o` is high together with the write of row 3.
- R8: At most one read is outstanding. A new `rd_req_o` appears only after `rd_vld_i` has answered the previous one.
- R9: `start_i` is ignored while `busy_o` is high. The running block completes with exactly four reads and four writes.
- R10: During reset and after it, with no start, `busy_o`, `rd_req_o`, `wr_vld_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; captures all block inputs when idle |
| busy_o | output | 1 | High from the cycle after an accepted start until the last write |
| coef_i | input | 240 | AC coefficients 1..15, signed 16 bits each |
| iscale_i | input | 240 | Inverse-scale entries for coefficients 1..15 |
| weight_i | input | 240 | Weight entries for coefficients 1..15 |
| qp_i | input | 4 | Left shift applied after scaling |
| dc_i | input | 16 | Signed DC term, placed directly into the transform |
| pred_i | input | 256 | Four interleaved 8-byte prediction rows |
| rd_req_o | output | 1 | One-cycle request for an old destination row |
| rd_row_o | output | 2 | Row index of the request |
| rd_vld_i | input | 1 | Response strobe for the open request |
| rd_data_i | input | 64 | Old destination row contents |
| wr_vld_o | output | 1 | Write strobe for a merged row |
| wr_row_o | output | 2 | Row index of the write |
| wr_data_o | output | 64 | Merged row: new even bytes, preserved odd bytes |
| done_o | output | 1 | High with the final row write |

## Verification
The checks take for granted that `rd_vld_i` is raised only while a request is open, exactly once per request, and one or more cycles after that request. Under this assumption the outstanding-read tracking, the read count before the first write, and the odd-byte comparison against the stored responses stay meaningful. The bench responder answers each request after a latency of one to three cycles and never raises `rd_vld_i` on its own. It injects an extra start pulse mid-block only to check that the pulse is ignored. Sweeps cover every shift value from 0 to 8 with randomized coefficients, tables, DC, prediction and old rows. Directed blocks add saturation, DC-only and clipping cases.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int unsigned NPT = 4;
  localparam int unsigned NCF = NPT * NPT;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DEQ    = 3'd1,
    ST_XFM    = 3'd2,
    ST_RDREQ  = 3'd3,
    ST_RDWAIT = 3'd4,
    ST_WR     = 3'd5
  } cr_state_e;
endpackage

// File: rtl/cr_dequant.sv
module cr_dequant
  import cr_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned QW  = 4,
  parameter int unsigned RSH = 4
) (
  input  logic [(NCF-1)*CW-1:0] coef_i,
  input  logic [(NCF-1)*CW-1:0] iscale_i,
  input  logic [(NCF-1)*CW-1:0] weight_i,
  input  logic [QW-1:0]         qp_i,
  output logic [(NCF-1)*CW-1:0] deq_o
);
  localparam int unsigned PWD = 2 * CW;
  localparam int unsigned EW  = PWD + 1;
  localparam logic [EW-1:0] RND  = EW'(1) << (RSH - 1);
  localparam logic [CW-1:0] SMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] SMIN = {1'b1, {(CW-1){1'b0}}};

  for (genvar i = 0; i < NCF - 1; i++) begin : g_lane
    logic [CW-1:0]         c_w;
    logic [CW-1:0]         s_w;
    logic [CW-1:0]         w_w;
    logic [CW-1:0]         x_w;
    logic signed [PWD-1:0] prod_w;
    logic signed [PWD-1:0] shl_w;
    logic signed [EW-1:0]  rnd_w;
    logic signed [EW-1:0]  shr_w;
    logic [EW-CW:0]        hi_w;
    logic [CW-1:0]         sat_w;

    assign c_w    = coef_i[i*CW +: CW];
    assign s_w    = iscale_i[i*CW +: CW];
    assign w_w    = weight_i[i*CW +: CW];
    assign x_w    = s_w * w_w;
    assign prod_w = $signed({{CW{c_w[CW-1]}}, c_w}) * $signed({{CW{x_w[CW-1]}}, x_w});
    assign shl_w  = prod_w <<< qp_i;
    assign rnd_w  = $signed({shl_w[PWD-1], shl_w}) + $signed(RND);
    assign shr_w  = rnd_w >>> RSH;
    assign hi_w   = shr_w[EW-1:CW-1];

    always_comb begin
      if ((&hi_w) || ~(|hi_w)) sat_w = shr_w[CW-1:0];
      else if (hi_w[EW-CW])    sat_w = SMIN;
      else                     sat_w = SMAX;
    end

    assign deq_o[i*CW +: CW] = sat_w;
  end
endmodule

// File: rtl/cr_bfly4.sv
module cr_bfly4 #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] a0,
  input  logic signed [W-1:0] a1,
  input  logic signed [W-1:0] a2,
  input  logic signed [W-1:0] a3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y3
);
  logic signed [W-1:0] e0, e1, e2, e3;

  assign e0 = a0 + a2;
  assign e1 = a0 - a2;
  assign e2 = (a1 >>> 1) - a3;
  assign e3 = a1 + (a3 >>> 1);

  assign y0 = e0 + e3;
  assign y1 = e1 + e2;
  assign y2 = e1 - e2;
  assign y3 = e0 - e3;
endmodule

// File: rtl/cr_itrans4.sv
module cr_itrans4
  import cr_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned RSH = 6
) (
  input  logic [NCF*CW-1:0] cf_i,
  output logic [NCF*CW-1:0] res_o
);
  localparam logic [CW:0] RND = (CW+1)'(1) << (RSH - 1);

  logic signed [CW-1:0] h_w [NCF];
  logic signed [CW-1:0] v_w [NCF];

  for (genvar r = 0; r < NPT; r++) begin : g_row
    cr_bfly4 #(.W(CW)) u_row (
      .a0 ($signed(cf_i[(r*NPT+0)*CW +: CW])),
      .a1 ($signed(cf_i[(r*NPT+1)*CW +: CW])),
      .a2 ($signed(cf_i[(r*NPT+2)*CW +: CW])),
      .a3 ($signed(cf_i[(r*NPT+3)*CW +: CW])),
      .y0 (h_w[r*NPT+0]),
      .y1 (h_w[r*NPT+1]),
      .y2 (h_w[r*NPT+2]),
      .y3 (h_w[r*NPT+3])
    );
  end

  for (genvar c = 0; c < NPT; c++) begin : g_col
    cr_bfly4 #(.W(CW)) u_col (
      .a0 (h_w[0*NPT+c]),
      .a1 (h_w[1*NPT+c]),
      .a2 (h_w[2*NPT+c]),
      .a3 (h_w[3*NPT+c]),
      .y0 (v_w[0*NPT+c]),
      .y1 (v_w[1*NPT+c]),
      .y2 (v_w[2*NPT+c]),
      .y3 (v_w[3*NPT+c])
    );
  end

  for (genvar k = 0; k < NCF; k++) begin : g_rnd
    logic signed [CW:0] sum_w;
    assign sum_w = $signed({v_w[k][CW-1], v_w[k]}) + $signed(RND);
    assign res_o[k*CW +: CW] = CW'(sum_w >>> RSH);
  end
endmodule

// File: rtl/cr_merge.sv
module cr_merge
  import cr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8
) (
  input  logic [2*NPT*PW-1:0] old_i,
  input  logic [2*NPT*PW-1:0] pred_i,
  input  logic [NPT*CW-1:0]   res_i,
  output logic [2*NPT*PW-1:0] row_o
);
  localparam int unsigned SW = CW + 2;

  logic [NPT*PW-1:0] pred_odd_unused;
  logic [NPT*PW-1:0] old_even_unused;

  for (genvar c = 0; c < NPT; c++) begin : g_pix
    logic [PW-1:0]        p_w;
    logic [CW-1:0]        r_w;
    logic signed [SW-1:0] s_w;
    logic [PW-1:0]        pix_w;

    assign p_w = pred_i[(2*c)*PW +: PW];
    assign r_w = res_i[c*CW +: CW];
    assign s_w = $signed({{2{r_w[CW-1]}}, r_w}) + $signed({{(SW-PW){1'b0}}, p_w});

    always_comb begin
      if (s_w[SW-1])          pix_w = '0;
      else if (|s_w[SW-2:PW]) pix_w = '1;
      else                    pix_w = s_w[PW-1:0];
    end

    assign pred_odd_unused[c*PW +: PW]  = pred_i[(2*c+1)*PW +: PW];
    assign old_even_unused[c*PW +: PW]  = old_i[(2*c)*PW +: PW];
    assign row_o[(2*c)*PW +: PW]        = pix_w;
    assign row_o[(2*c+1)*PW +: PW]      = old_i[(2*c+1)*PW +: PW];
  end
endmodule

// File: rtl/chroma_recon4x4.sv
module chroma_recon4x4
  import cr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8,
  parameter int unsigned QW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  output logic                      busy_o,
  input  logic [(NCF-1)*CW-1:0]     coef_i,
  input  logic [(NCF-1)*CW-1:0]     iscale_i,
  input  logic [(NCF-1)*CW-1:0]     weight_i,
  input  logic [QW-1:0]             qp_i,
  input  logic [CW-1:0]             dc_i,
  input  logic [NPT*2*NPT*PW-1:0]   pred_i,
  output logic                      rd_req_o,
  output logic [$clog2(NPT)-1:0]    rd_row_o,
  input  logic                      rd_vld_i,
  input  logic [2*NPT*PW-1:0]       rd_data_i,
  output logic                      wr_vld_o,
  output logic [$clog2(NPT)-1:0]    wr_row_o,
  output logic [2*NPT*PW-1:0]       wr_data_o,
  output logic                      done_o
);
  localparam int unsigned ROW_W = 2 * NPT * PW;
  localparam int unsigned RW    = $clog2(NPT);
  localparam int unsigned ACW   = (NCF - 1) * CW;
  localparam logic [RW-1:0] LAST = RW'(NPT - 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sq;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  // control state
  cr_state_e     state_q, state_d;
  logic [RW-1:0] row_q, row_d;
  logic          acc_en, deq_en, res_en, old_en;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    acc_en  = 1'b0;
    deq_en  = 1'b0;
    res_en  = 1'b0;
    old_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          acc_en  = 1'b1;
          state_d = ST_DEQ;
        end
      end
      ST_DEQ: begin
        deq_en  = 1'b1;
        state_d = ST_XFM;
      end
      ST_XFM: begin
        res_en  = 1'b1;
        row_d   = '0;
        state_d = ST_RDREQ;
      end
      ST_RDREQ: begin
        state_d = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (rd_vld_i) begin
          old_en = 1'b1;
          if (row_q == LAST) begin
            row_d   = '0;
            state_d = ST_WR;
          end else begin
            row_d   = row_q + RW'(1);
            state_d = ST_RDREQ;
          end
        end
      end
      ST_WR: begin
        if (row_q == LAST) state_d = ST_IDLE;
        else               row_d   = row_q + RW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
    end
  end

  // captured block inputs
  logic [ACW-1:0]       coef_q, isc_q, wt_q;
  logic [QW-1:0]        qp_q;
  logic [CW-1:0]        dc_q;
  logic [NPT*ROW_W-1:0] pred_q;

  always_ff @(posedge clk) begin
    if (acc_en) begin
      coef_q <= coef_i;
      isc_q  <= iscale_i;
      wt_q   <= weight_i;
      qp_q   <= qp_i;
      dc_q   <= dc_i;
      pred_q <= pred_i;
    end
  end

  // stage 1: dequantize AC terms, DC taken from outside
  logic [ACW-1:0]    deq_w;
  logic [NCF*CW-1:0] deq_q;

  cr_dequant #(.CW(CW), .QW(QW), .RSH(4)) u_deq (
    .coef_i   (coef_q),
    .iscale_i (isc_q),
    .weight_i (wt_q),
    .qp_i     (qp_q),
    .deq_o    (deq_w)
  );

  always_ff @(posedge clk) begin
    if (deq_en) deq_q <= {deq_w, dc_q};
  end

  // stage 2: 2-D inverse transform and residual rounding
  logic [NCF*CW-1:0] res_w;
  logic [NCF*CW-1:0] res_q;

  cr_itrans4 #(.CW(CW), .RSH(6)) u_xfm (
    .cf_i  (deq_q),
    .res_o (res_w)
  );

  always_ff @(posedge clk) begin
    if (res_en) res_q <= res_w;
  end

  // old destination rows
  logic [ROW_W-1:0] old_q [NPT];

  always_ff @(posedge clk) begin
    if (old_en) old_q[row_q] <= rd_data_i;
  end

  // merge for the row being written
  logic [ROW_W-1:0]   pred_row_w;
  logic [NPT*CW-1:0]  res_row_w;
  logic [ROW_W-1:0]   merged_w;

  assign pred_row_w = pred_q[row_q*ROW_W +: ROW_W];
  assign res_row_w  = res_q[row_q*NPT*CW +: NPT*CW];

  cr_merge #(.CW(CW), .PW(PW)) u_mrg (
    .old_i  (old_q[row_q]),
    .pred_i (pred_row_w),
    .res_i  (res_row_w),
    .row_o  (merged_w)
  );

  // outputs
  assign busy_o    = (state_q != ST_IDLE);
  assign rd_req_o  = (state_q == ST_RDREQ);
  assign rd_row_o  = row_q;
  assign wr_vld_o  = (state_q == ST_WR);
  assign wr_row_o  = row_q;
  assign wr_data_o = merged_w;
  assign done_o    = (state_q == ST_WR) && (row_q == LAST);
endmodule

// File: rtl/cr_recon_chk.sv
module cr_recon_chk
  import cr_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     rd_req_o,
  input logic [$clog2(NPT)-1:0]   rd_row_o,
  input logic                     rd_vld_i,
  input logic [2*NPT*PW-1:0]      rd_data_i,
  input logic                     wr_vld_o,
  input logic [$clog2(NPT)-1:0]   wr_row_o,
  input logic [2*NPT*PW-1:0]      wr_data_o,
  input logic                     done_o
);
  localparam int unsigned ROW_W = 2 * NPT * PW;
  localparam int unsigned RW    = $clog2(NPT);

  function automatic logic [ROW_W-1:0] odd_mask();
    logic [ROW_W-1:0] m;
    m = '0;
    for (int b = 0; b < 2 * NPT; b++) begin
      if (b % 2 == 1) m[b*PW +: PW] = '1;
    end
    return m;
  endfunction

  localparam logic [ROW_W-1:0] ODD_MASK = odd_mask();

  logic             pend_q;
  logic [RW-1:0]    prow_q;
  logic [RW:0]      nrd_q;
  logic [ROW_W-1:0] seen_q [NPT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prow_q <= '0;
      nrd_q  <= '0;
    end else begin
      if (rd_req_o) begin
        pend_q <= 1'b1;
        prow_q <= rd_row_o;
      end else if (rd_vld_i) begin
        pend_q <= 1'b0;
      end
      if (start_i && !busy_o)                                  nrd_q <= '0;
      else if (pend_q && rd_vld_i && nrd_q != (RW+1)'(NPT))   nrd_q <= nrd_q + (RW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (pend_q && rd_vld_i) seen_q[prow_q] <= rd_data_i;
  end

  // R8
  one_open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !pend_q);

  // R4
  reads_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |-> (nrd_q == (RW+1)'(NPT)));

  // R7
  write_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_o && wr_row_o != RW'(NPT-1)) |=> (wr_vld_o && wr_row_o == $past(wr_row_o) + RW'(1)));

  // R7
  done_last_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wr_vld_o && wr_row_o == RW'(NPT-1)));

  // R5
  odd_bytes_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld_o |-> ((wr_data_o & ODD_MASK) == (seen_q[wr_row_o] & ODD_MASK)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_o && !wr_vld_o && !done_o));
endmodule

bind chroma_recon4x4 cr_recon_chk #(.PW(PW)) u_chk (.*);

// File: tb/tb_chroma_recon4x4.sv
module tb_chroma_recon4x4;
  import cr_pkg::*;

  localparam int CW    = 16;
  localparam int PW    = 8;
  localparam int QW    = 4;
  localparam int ROW_W = 2 * NPT * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                   start_i = 1'b0;
  logic                   busy_o;
  logic [(NCF-1)*CW-1:0]  coef_i = '0;
  logic [(NCF-1)*CW-1:0]  iscale_i = '0;
  logic [(NCF-1)*CW-1:0]  weight_i = '0;
  logic [QW-1:0]          qp_i = '0;
  logic [CW-1:0]          dc_i = '0;
  logic [NPT*ROW_W-1:0]   pred_i = '0;
  logic                   rd_req_o;
  logic [1:0]             rd_row_o;
  logic                   rd_vld_i = 1'b0;
  logic [ROW_W-1:0]       rd_data_i = '0;
  logic                   wr_vld_o;
  logic [1:0]             wr_row_o;
  logic [ROW_W-1:0]       wr_data_o;
  logic                   done_o;

  chroma_recon4x4 #(.CW(CW), .PW(PW), .QW(QW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .coef_i(coef_i), .iscale_i(iscale_i), .weight_i(weight_i),
    .qp_i(qp_i), .dc_i(dc_i), .pred_i(pred_i),
    .rd_req_o(rd_req_o), .rd_row_o(rd_row_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .wr_vld_o(wr_vld_o), .wr_row_o(wr_row_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  int errs = 0;
  int chks = 0;

  shortint          cf  [NCF];
  int               isc [NCF];
  int               wt  [NCF];
  int               qpv;
  shortint          dcv;
  logic [ROW_W-1:0] pr   [NPT];
  logic [ROW_W-1:0] mem  [NPT];
  logic [ROW_W-1:0] expr [NPT];
  logic [ROW_W-1:0] got  [NPT];

  int rd_cnt, nwr, rd_at_wr;
  bit seq_bad, dup_bad, blk_done;

  localparam logic [ROW_W-1:0] ODDM = 64'hFF00_FF00_FF00_FF00;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, chks);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [ROW_W-1:0] act,
                     input logic [ROW_W-1:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- reference model ----------
  function automatic shortint deq1(input int i);
    logic [15:0] x;
    longint      p;
    int          p32;
    longint      r;
    x   = 16'(isc[i] * wt[i]);
    p   = longint'(cf[i]) * longint'($signed(x));
    p32 = int'(p);
    p32 = p32 <<< qpv;
    r   = (longint'(p32) + 8) >>> 4;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return shortint'(r);
  endfunction

  task automatic bf(input shortint a0, input shortint a1, input shortint a2, input shortint a3,
                    output shortint y0, output shortint y1, output shortint y2, output shortint y3);
    shortint e0, e1, e2, e3;
    e0 = a0 + a2;
    e1 = a0 - a2;
    e2 = (a1 >>> 1) - a3;
    e3 = a1 + (a3 >>> 1);
    y0 = e0 + e3;
    y1 = e1 + e2;
    y2 = e1 - e2;
    y3 = e0 - e3;
  endtask

  task automatic model();
    shortint d [NCF];
    shortint h [NCF];
    shortint v [NCF];
    d[0] = dcv;
    for (int i = 1; i < NCF; i++) d[i] = deq1(i);
    for (int r = 0; r < NPT; r++)
      bf(d[4*r], d[4*r+1], d[4*r+2], d[4*r+3], h[4*r], h[4*r+1], h[4*r+2], h[4*r+3]);
    for (int c = 0; c < NPT; c++)
      bf(h[c], h[4+c], h[8+c], h[12+c], v[c], v[4+c], v[8+c], v[12+c]);
    for (int r = 0; r < NPT; r++) begin
      expr[r] = mem[r];
      for (int c = 0; c < NPT; c++) begin
        int rr, s;
        rr = (int'(v[4*r+c]) + 32) >>> 6;
        s  = int'(pr[r][16*c +: 8]) + rr;
        if (s < 0)   s = 0;
        if (s > 255) s = 255;
        expr[r][16*c +: 8] = 8'(s);
      end
    end
  endtask

  task automatic drive();
    for (int i = 1; i < NCF; i++) begin
      coef_i[(i-1)*CW +: CW]   = cf[i];
      iscale_i[(i-1)*CW +: CW] = 16'(isc[i]);
      weight_i[(i-1)*CW +: CW] = 16'(wt[i]);
    end
    for (int r = 0; r < NPT; r++) pred_i[r*ROW_W +: ROW_W] = pr[r];
    qp_i = QW'(qpv);
    dc_i = dcv;
  endtask

  // ---------- read responder ----------
  initial begin
    forever begin
      @(negedge clk);
      while (rd_req_o) begin
        int row, lat;
        row = int'(rd_row_o);
        lat = int'($urandom_range(1, 3));
        repeat (lat) begin
          @(negedge clk);
          if (rd_req_o) dup_bad = 1'b1;
        end
        rd_vld_i  = 1'b1;
        rd_data_i = mem[row];
        rd_cnt++;
        @(negedge clk);
        rd_vld_i  = 1'b0;
      end
    end
  end

  // ---------- write capture ----------
  initial begin
    forever begin
      @(negedge clk);
      if (wr_vld_o) begin
        got[wr_row_o] = wr_data_o;
        if (nwr == 0) rd_at_wr = rd_cnt;
        if (int'(wr_row_o) != nwr) seq_bad = 1'b1;
        nwr++;
        if (done_o) begin
          blk_done = 1'b1;
          if (wr_row_o != 2'd3) seq_bad = 1'b1;
        end
      end
    end
  end

  // ---------- one block ----------
  task automatic run_block(input bit poke, input string tag);
    int cnt;
    model();
    drive();
    rd_cnt = 0; nwr = 0; rd_at_wr = -1;
    seq_bad = 1'b0; dup_bad = 1'b0; blk_done = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (!blk_done && cnt < 300) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 3) begin
        start_i = 1'b1;
        coef_i  = ~coef_i;
        dc_i    = ~dc_i;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    if (!blk_done) begin
      chk(1'b0, "watchdog: block did not finish", 64'(cnt), 64'd300);
      return;
    end
    repeat (3) @(negedge clk);
    for (int r = 0; r < NPT; r++)
      chk(got[r] === expr[r], $sformatf("%s row %0d", tag, r), got[r], expr[r]);
    for (int r = 0; r < NPT; r++)
      chk((got[r] & ODDM) === (mem[r] & ODDM), $sformatf("R5 odd bytes row %0d", r),
          got[r] & ODDM, mem[r] & ODDM);
    chk(rd_at_wr == 4, "R4 reads before first write", 64'(rd_at_wr), 64'd4);
    chk(!seq_bad && nwr == 4, "R7 write order and count", 64'(nwr), 64'd4);
    chk(!dup_bad, "R8 second request while open", 64'(dup_bad), 64'd0);
    if (poke)
      chk(rd_cnt == 4 && nwr == 4 && !busy_o, "R9 start while busy ignored",
          64'(rd_cnt * 16 + nwr), 64'(4 * 16 + 4));
    for (int r = 0; r < NPT; r++) mem[r] = got[r];
  endtask

  task automatic rand_block(input int q);
    for (int i = 0; i < NCF; i++) begin
      cf[i]  = shortint'(int'($urandom_range(0, 255)) - 128);
      isc[i] = int'($urandom_range(1, 40));
      wt[i]  = int'($urandom_range(1, 24));
    end
    qpv = q;
    dcv = shortint'(int'($urandom_range(0, 1200)) - 600);
    for (int r = 0; r < NPT; r++) begin
      pr[r]  = {$urandom, $urandom};
      mem[r] = {$urandom, $urandom};
    end
  endtask

  task automatic zero_block();
    for (int i = 0; i < NCF; i++) begin
      cf[i] = 0; isc[i] = 16; wt[i] = 16;
    end
    qpv = 0;
  endtask

  // ---------- global watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    chks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  // ---------- main sequence ----------
  initial begin
    logic [ROW_W-1:0] ref_even [NPT];

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !wr_vld_o && !done_o, "R10 outputs during reset",
        {60'd0, busy_o, rd_req_o, wr_vld_o, done_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !rd_req_o && !wr_vld_o && !done_o, "R10 idle after reset",
        {60'd0, busy_o, rd_req_o, wr_vld_o, done_o}, 64'd0);

    // sweep over every shift value with random blocks (R1, R6)
    for (int q = 0; q <= 8; q++) begin
      for (int n = 0; n < 12; n++) begin
        rand_block(q);
        run_block(n == 5, "R1/R6 sweep");
      end
    end

    // R1: positive and negative saturation of dequantized terms
    rand_block(6);
    cf[5] = 32767;  isc[5] = 200; wt[5] = 100;
    cf[6] = -32768; isc[6] = 120; wt[6] = 90;
    cf[9] = 30000;  isc[9] = 25;  wt[9] = 16;
    run_block(1'b0, "R1 saturation");

    // R2: DC only block, every residual equals (dc+32)>>>6
    zero_block();
    dcv = 640;
    for (int r = 0; r < NPT; r++) begin
      pr[r]  = 64'h0064_0064_0064_0064;
      mem[r] = {$urandom, $urandom};
    end
    run_block(1'b0, "R2 dc only");
    chk(got[2][16 +: 8] == 8'd110, "R2 dc pixel value", 64'(got[2][16 +: 8]), 64'd110);

    // R2: negative DC with rounding toward the nearest
    dcv = -97;
    run_block(1'b0, "R2 negative dc");
    chk(got[3][48 +: 8] == 8'd98, "R2 negative dc pixel", 64'(got[3][48 +: 8]), 64'd98);

    // R3: odd prediction bytes have no effect
    rand_block(3);
    run_block(1'b0, "R3 base");
    for (int r = 0; r < NPT; r++) ref_even[r] = got[r] & ~ODDM;
    for (int r = 0; r < NPT; r++) pr[r] = pr[r] ^ ODDM;
    run_block(1'b0, "R3 odd pred flipped");
    for (int r = 0; r < NPT; r++)
      chk((got[r] & ~ODDM) === ref_even[r], $sformatf("R3 even bytes unchanged row %0d", r),
          got[r] & ~ODDM, ref_even[r]);

    // R6: clip at the top and at the bottom of the pixel range
    zero_block();
    dcv = 3000;
    for (int r = 0; r < NPT; r++) begin
      pr[r]  = 64'h00F0_00FF_00C8_00FA;
      mem[r] = 64'hA5A5_A5A5_A5A5_A5A5;
    end
    run_block(1'b0, "R6 clip high");
    chk(got[0][0 +: 8] == 8'd255, "R6 clip to 255", 64'(got[0][0 +: 8]), 64'd255);
    dcv = -3000;
    for (int r = 0; r < NPT; r++) pr[r] = 64'h0010_0000_0030_0005;
    run_block(1'b0, "R6 clip low");
    chk(got[1][32 +: 8] == 8'd0, "R6 clip to 0", 64'(got[1][32 +: 8]), 64'd0);

    // R9: start while busy, on a block with a known answer
    rand_block(2);
    run_block(1'b1, "R9 block with extra start");

    summary();
    $finish;
  end
endmodule